// File: doc/BRIEF.md
# Circular Buffer Write Pointer Manager

This block keeps the byte-address write pointer of one channel whose section data is stored in a circular buffer in external memory. A host programs the buffer's start and end positions through a small register write port. Each accepted store strobe moves the pointer forward by one byte. When the pointer reaches the end location, the next store sends it back to the start.

The block also holds a section-start pointer. When a section completes, the pointer position where the next section will begin is saved. When the current section is flagged as bad, the write pointer goes back to that saved position, so the partial data that was already stored is abandoned and later overwritten. Both pointers can be read back at all times. Channels without rollback are built with `ROLLBACK_EN = 0`. In that build the error input has no effect and the section pointer reads as zero.

Pointers are `HI_W + LO_W` bits wide, 21 bits by default. The start address is put together from a 16-bit upper field and a 5-bit lower field, written separately. The end location comes from a single 16-bit value N and equals 16*N + 15.

Top module: `cbw_wptr_mgr`

## Requirements
- R1: After reset both pointers read 0. The start address is 0 and the end value N is 0, so the end location is 15.
- R2: A configuration write with `cfg_sel_i` = 0 sets the start upper field from `cfg_wdata_i[15:0]`. A write with `cfg_sel_i` = 1 sets the start lower field from `cfg_wdata_i[4:0]`. The start address is {upper, lower}. On the next cycle both pointers equal the new start address.
- R3: A configuration write with `cfg_sel_i` = 2 sets N. The end location becomes 16*N + 15, so N = 0xFFFF gives 1048575.
- R4: A store with the write pointer away from the end location increments the write pointer by one.
- R5: A store with the write pointer equal to the end location loads the write pointer with the start address. The byte at the end location is therefore written before the wrap.
- R6: A section-done pulse copies the write pointer into the section pointer. The copied value includes a store in the same cycle.
- R7: A section-error pulse sets the write pointer to the section pointer. A store or section-done pulse in the same cycle is discarded.
- R8: A start-address write in the same cycle as a store or error takes priority. Both pointers take the new start address.
- R9: A configuration write with `cfg_sel_i` = 3 changes neither pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Field select: 0 start upper, 1 start lower, 2 end value, 3 unused |
| cfg_wdata_i | input | 16 | Configuration write data |
| store_i | input | 1 | One byte stored at the write pointer |
| sec_done_i | input | 1 | Current section completed |
| sec_err_i | input | 1 | Current section is bad; discard it |
| wr_ptr_o | output | 21 | Write pointer read-back |
| last_ptr_o | output | 21 | Section-start pointer read-back |

## Verification
The hardest case to reach is a rollback whose saved section start lies just before the end location, so that the pointer has already wrapped past the end when the error arrives. The stimulus programs a small buffer, stores up to two bytes short of the end, and marks a section boundary there. It then stores across the wrap and raises the error, which should pull the pointer back behind the wrap point. The highest end value is reached by placing the start one byte below the largest end location and checking that the pointer climbs to it and then falls back.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  typedef enum logic [1:0] {
    SEL_START_HI = 2'd0,
    SEL_START_LO = 2'd1,
    SEL_END_HI   = 2'd2,
    SEL_RSVD     = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/cbw_regs.sv
module cbw_regs
  import cbw_pkg::*;
#(
  parameter int HI_W   = 16,
  parameter int LO_W   = 5,
  parameter int FILL_W = 4,
  localparam int AW    = HI_W + LO_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [HI_W-1:0] cfg_wdata_i,
  output logic [AW-1:0] start_addr_o,
  output logic [AW-1:0] start_next_o,
  output logic          start_load_o,
  output logic [AW-1:0] end_addr_o
);
  logic [HI_W-1:0] start_hi_q, end_hi_q;
  logic [LO_W-1:0] start_lo_q;
  logic hi_we, lo_we, end_we;

  assign hi_we  = cfg_we_i && (cfg_sel_e'(cfg_sel_i) == SEL_START_HI);
  assign lo_we  = cfg_we_i && (cfg_sel_e'(cfg_sel_i) == SEL_START_LO);
  assign end_we = cfg_we_i && (cfg_sel_e'(cfg_sel_i) == SEL_END_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_hi_q <= '0;
      start_lo_q <= '0;
      end_hi_q   <= '0;
    end else begin
      if (hi_we)  start_hi_q <= cfg_wdata_i;
      if (lo_we)  start_lo_q <= cfg_wdata_i[LO_W-1:0];
      if (end_we) end_hi_q   <= cfg_wdata_i;
    end
  end

  assign start_addr_o = {start_hi_q, start_lo_q};
  // composed value the pointers take on the same edge as the field update
  assign start_next_o = hi_we ? {cfg_wdata_i, start_lo_q}
                              : {start_hi_q, cfg_wdata_i[LO_W-1:0]};
  assign start_load_o = hi_we || lo_we;
  assign end_addr_o   = AW'({end_hi_q, {FILL_W{1'b1}}});
endmodule

// File: rtl/cbw_ptr_next.sv
module cbw_ptr_next #(
  parameter int AW          = 21,
  parameter bit ROLLBACK_EN = 1'b1
) (
  input  logic [AW-1:0] wr_ptr_i,
  input  logic [AW-1:0] last_ptr_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW-1:0] start_next_i,
  input  logic [AW-1:0] end_addr_i,
  input  logic          start_load_i,
  input  logic          store_i,
  input  logic          sec_err_i,
  output logic [AW-1:0] wr_nxt_o,
  output logic          rollback_o
);
  logic at_end;

  assign at_end     = (wr_ptr_i == end_addr_i);
  assign rollback_o = ROLLBACK_EN && sec_err_i && !start_load_i;

  always_comb begin
    wr_nxt_o = wr_ptr_i;
    if (start_load_i)     wr_nxt_o = start_next_i;
    else if (rollback_o)  wr_nxt_o = last_ptr_i;
    else if (store_i)     wr_nxt_o = at_end ? start_addr_i : wr_ptr_i + AW'(1);
  end
endmodule

// File: rtl/cbw_sect.sv
module cbw_sect #(
  parameter int AW          = 21,
  parameter bit ROLLBACK_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_load_i,
  input  logic [AW-1:0] start_next_i,
  input  logic          rollback_i,
  input  logic          sec_done_i,
  input  logic [AW-1:0] wr_nxt_i,
  output logic [AW-1:0] last_ptr_o
);
  if (ROLLBACK_EN) begin : g_rb
    logic [AW-1:0] last_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        last_q <= '0;
      else if (start_load_i)              last_q <= start_next_i;
      else if (sec_done_i && !rollback_i) last_q <= wr_nxt_i;
    end
    assign last_ptr_o = last_q;
  end else begin : g_no_rb
    logic unused;
    assign unused     = ^{clk_i, rst_ni, start_load_i, start_next_i,
                          rollback_i, sec_done_i, wr_nxt_i};
    assign last_ptr_o = '0;
  end
endmodule

// File: rtl/cbw_wptr_mgr.sv
module cbw_wptr_mgr #(
  parameter int HI_W        = 16,
  parameter int LO_W        = 5,
  parameter int FILL_W      = 4,
  parameter bit ROLLBACK_EN = 1'b1,
  localparam int AW         = HI_W + LO_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_sel_i,
  input  logic [HI_W-1:0] cfg_wdata_i,
  input  logic            store_i,
  input  logic            sec_done_i,
  input  logic            sec_err_i,
  output logic [AW-1:0]   wr_ptr_o,
  output logic [AW-1:0]   last_ptr_o
);
  logic [AW-1:0] start_addr, start_next, end_addr, wr_nxt, wr_q;
  logic          start_load, rollback;

  cbw_regs #(.HI_W(HI_W), .LO_W(LO_W), .FILL_W(FILL_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_sel_i    (cfg_sel_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .start_addr_o (start_addr),
    .start_next_o (start_next),
    .start_load_o (start_load),
    .end_addr_o   (end_addr)
  );

  cbw_ptr_next #(.AW(AW), .ROLLBACK_EN(ROLLBACK_EN)) u_next (
    .wr_ptr_i     (wr_q),
    .last_ptr_i   (last_ptr_o),
    .start_addr_i (start_addr),
    .start_next_i (start_next),
    .end_addr_i   (end_addr),
    .start_load_i (start_load),
    .store_i      (store_i),
    .sec_err_i    (sec_err_i),
    .wr_nxt_o     (wr_nxt),
    .rollback_o   (rollback)
  );

  cbw_sect #(.AW(AW), .ROLLBACK_EN(ROLLBACK_EN)) u_sect (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_load_i (start_load),
    .start_next_i (start_next),
    .rollback_i   (rollback),
    .sec_done_i   (sec_done_i),
    .wr_nxt_i     (wr_nxt),
    .last_ptr_o   (last_ptr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= '0;
    else         wr_q <= wr_nxt;
  end

  assign wr_ptr_o = wr_q;
endmodule

// File: rtl/cbw_wptr_chk.sv
module cbw_wptr_chk #(
  parameter int AW          = 21,
  parameter bit ROLLBACK_EN = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [1:0]    cfg_sel_i,
  input logic          store_i,
  input logic          sec_done_i,
  input logic          sec_err_i,
  input logic [AW-1:0] wr_ptr_o,
  input logic [AW-1:0] last_ptr_o,
  input logic [AW-1:0] start_addr,
  input logic [AW-1:0] end_addr
);
  logic start_wr;
  assign start_wr = cfg_we_i && (cfg_sel_i == 2'd0 || cfg_sel_i == 2'd1);

  // R2
  start_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr |=> (ROLLBACK_EN == 1'b0) || (wr_ptr_o == last_ptr_o));

  // R4
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i && !sec_err_i && !start_wr && wr_ptr_o != end_addr
      |=> wr_ptr_o == $past(wr_ptr_o) + AW'(1));

  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i && !sec_err_i && !start_wr && wr_ptr_o == end_addr
      |=> wr_ptr_o == $past(start_addr));

  // R6
  mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ROLLBACK_EN && sec_done_i && !sec_err_i && !start_wr
      |=> last_ptr_o == wr_ptr_o);

  // R7
  rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ROLLBACK_EN && sec_err_i && !start_wr |=> wr_ptr_o == $past(last_ptr_o));

  // R9
  rsvd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_sel_i == 2'd3 && !store_i && !sec_err_i && !sec_done_i
      |=> $stable(wr_ptr_o) && $stable(last_ptr_o));
endmodule

bind cbw_wptr_mgr cbw_wptr_chk #(.AW(AW), .ROLLBACK_EN(ROLLBACK_EN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_sel_i  (cfg_sel_i),
  .store_i    (store_i),
  .sec_done_i (sec_done_i),
  .sec_err_i  (sec_err_i),
  .wr_ptr_o   (wr_ptr_o),
  .last_ptr_o (last_ptr_o),
  .start_addr (start_addr),
  .end_addr   (end_addr)
);

// File: tb/sim_cbw_wptr_mgr.sv
module sim_cbw_wptr_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          store = 1'b0, done = 1'b0, err = 1'b0;
  logic [AW-1:0] wr_ptr, last_ptr;
  int            n_chk = 0, n_fail = 0;
  bit            ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbw_wptr_mgr u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_sel_i   (cfg_sel),
    .cfg_wdata_i (cfg_wdata),
    .store_i     (store),
    .sec_done_i  (done),
    .sec_err_i   (err),
    .wr_ptr_o    (wr_ptr),
    .last_ptr_o  (last_ptr)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // inputs applied just after a falling edge, results read at the next one
  task automatic tick(input logic st, input logic dn, input logic er,
                      input logic we, input logic [1:0] sel, input logic [15:0] wd);
    store = st; done = dn; err = er; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    store = 0; done = 0; err = 0; cfg_we = 0;
  endtask

  task automatic stores(input int n);
    for (int i = 0; i < n; i++) tick(1, 0, 0, 0, 2'd0, 16'h0);
  endtask

  task automatic t_reset();
    chk("R1 wr after reset", wr_ptr, 21'h0);
    chk("R1 last after reset", last_ptr, 21'h0);
    stores(15);
    chk("R1 reach default end 15", wr_ptr, 21'd15);
    stores(1);
    chk("R1 R5 wrap at default end", wr_ptr, 21'h0);
  endtask

  task automatic t_config();
    tick(0, 0, 0, 1, 2'd0, 16'h0010);
    chk("R2 wr after start upper", wr_ptr, 21'h200);
    chk("R2 last after start upper", last_ptr, 21'h200);
    tick(0, 0, 0, 1, 2'd1, 16'hFFE3);
    chk("R2 wr after start lower", wr_ptr, 21'h203);
    tick(0, 0, 0, 1, 2'd2, 16'h0021);
    chk("R3 end write leaves wr", wr_ptr, 21'h203);
    stores(5);
    chk("R4 five stores", wr_ptr, 21'h208);
    chk("R4 last untouched", last_ptr, 21'h203);
  endtask

  task automatic t_wrap();
    stores(23);
    chk("R3 R5 reach end 0x21F", wr_ptr, 21'h21F);
    stores(1);
    chk("R5 wrap to start", wr_ptr, 21'h203);
  endtask

  task automatic t_section();
    tick(1, 1, 0, 0, 2'd0, 16'h0);
    chk("R6 wr with done", wr_ptr, 21'h204);
    chk("R6 last includes store", last_ptr, 21'h204);
    stores(3);
    tick(0, 0, 1, 0, 2'd0, 16'h0);
    chk("R7 rewind", wr_ptr, 21'h204);
    stores(2);
    tick(1, 0, 1, 0, 2'd0, 16'h0);
    chk("R7 store dropped on error", wr_ptr, 21'h204);
    stores(26);
    tick(0, 1, 0, 0, 2'd0, 16'h0);
    chk("R6 mark near end", last_ptr, 21'h21E);
    stores(3);
    chk("R5 past wrap", wr_ptr, 21'h204);
    tick(0, 0, 1, 0, 2'd0, 16'h0);
    chk("R7 rewind across wrap", wr_ptr, 21'h21E);
  endtask

  task automatic t_priority();
    tick(1, 1, 1, 1, 2'd0, 16'h0001);
    chk("R8 wr start wins", wr_ptr, 21'h23);
    chk("R8 last start wins", last_ptr, 21'h23);
    tick(0, 0, 0, 1, 2'd3, 16'hFFFF);
    chk("R9 wr unchanged", wr_ptr, 21'h23);
    chk("R9 last unchanged", last_ptr, 21'h23);
    stores(1);
    chk("R9 R4 still steps", wr_ptr, 21'h24);
  endtask

  task automatic t_max_end();
    tick(0, 0, 0, 1, 2'd2, 16'hFFFF);
    tick(0, 0, 0, 1, 2'd0, 16'h7FFF);
    tick(0, 0, 0, 1, 2'd1, 16'h001E);
    chk("R2 start 0xFFFFE", wr_ptr, 21'hFFFFE);
    stores(1);
    chk("R3 reach 1048575", wr_ptr, 21'd1048575);
    stores(1);
    chk("R3 R5 wrap at max end", wr_ptr, 21'hFFFFE);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_wrap();
    t_section();
    t_priority();
    t_max_end();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end
endmodule